// File: doc/BRIEF.md
# Serial DAC Command Interface

This block is the digital front end of a serially loaded 12-bit digital-to-analog converter. A host drives three pins: an active-low select, a serial clock and a data line. The block synchronises all three into a faster system clock. Serial-clock rising edges seen while select is low shift the data bit into a 16-bit shift register. When select rises, the block decodes the word it has gathered. The register pair is double-buffered: an input stage and an output (DAC) stage. They can be loaded together or separately. The output stage is exported as a plain 12-bit code to the analog macro.

Control words with both control bits set are commands for the block itself rather than data. These commands can raise a one-cycle shutdown request towards the power controller, set or clear a general-purpose logic pin, or change the timing of the serial output. The serial output is the far end of the shift register, so several blocks can be chained on one data line. In the alternate timing mode that output moves on the falling serial-clock edge instead of the rising one. A synchronous clear input returns the logic pin to its low default.

Top module: `sdac_cmd_front`

## Requirements
- R1: After reset, `dac_code` is 0, `upo` is low, `sdo` is low and `shdn_req` is low. The input stage and the timing mode are also cleared, so the output moves on rising serial-clock edges.
- R2: A word is 16 bits, most significant bit first. Bits 15:14 are the control field, bits 13:2 are the 12-bit data (bit 13 is its MSB), and bits 1:0 are ignored.
- R3: Serial-clock edges while `cs_n_in` is high change neither the shift register, nor `sdo`, nor any later decoded word.
- R4: Control 00 copies the data field into the input stage and leaves `dac_code` unchanged.
- R5: Control 01 writes the data field into both stages; `dac_code` shows it within 6 system clocks of `cs_n_in` rising.
- R6: Control 10 copies the input stage to `dac_code` and ignores the data field.
- R7: Control 11 with data bits 11:10 = 00 changes nothing. With data bits 11:10 = 01 it gives exactly one `shdn_req` pulse, one system clock wide, and changes no stage and not `upo`.
- R8: Control 11 with data bits 11:9 = 100 drives `upo` low, and with 101 drives it high. `upo` holds its value through every other word, including shutdown requests.
- R9: `clear_in` high at a clock edge forces `upo` low on that edge.
- R10: A word is decoded when select rises after a non-zero multiple of 8 serial-clock rises. Pauses with select held low, such as two 8-bit bursts, do not matter. The decoded word is the last 16 bits shifted in.
- R11: If select rises after a count of rises that is not a multiple of 8, the word is discarded and no stage, mode or `upo` changes.
- R12: In the standard mode, `sdo` equals the bit shifted in 16 rises earlier and changes just after each rising serial-clock edge.
- R13: Control 11 with data bits 11:9 = 110 selects the alternate mode, in which `sdo` takes the same sequence but changes after the falling edge. Pattern 111 returns to the standard mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_in | input | 1 | Asynchronous active-low select |
| sclk_in | input | 1 | Asynchronous serial clock |
| sdi_in | input | 1 | Asynchronous serial data |
| clear_in | input | 1 | Synchronous clear of the logic pin, active high |
| dac_code | output | 12 | Output-stage code for the converter |
| upo | output | 1 | General-purpose logic output |
| sdo | output | 1 | Serial data out, end of the shift register |
| shdn_req | output | 1 | One-cycle shutdown strobe to the power controller |

## Verification
The input stage has no port of its own. A wrong load into it therefore stays hidden until a later copy command, and then `dac_code` shows it about five clocks after select rises. A corrupted shift register or bit counter shows up sooner, as a wrong bit on `sdo` at the next serial-clock edge or as a wrongly accepted or discarded word at the end of the frame. A wrong mode bit shows up as `sdo` moving half a serial period early or late. The bench checks `sdo` in both halves of every serial period to catch this.

// File: rtl/sdac_pkg.sv
// Shared types for the serial DAC command interface.
// Assumes a two-bit control field followed by the data field.
package sdac_pkg;

    typedef enum logic [1:0] {
        OP_LOAD_IN  = 2'b00,
        OP_LOAD_ALL = 2'b01,
        OP_TRANSFER = 2'b10,
        OP_SPECIAL  = 2'b11
    } sdac_op_e;

    typedef enum logic [2:0] {
        AUX_NOP,
        AUX_SHDN,
        AUX_PIN_LO,
        AUX_PIN_HI,
        AUX_MODE_ALT,
        AUX_MODE_STD
    } sdac_aux_e;

    // Map the top three data bits of a special word onto an action.
    function automatic sdac_aux_e decode_aux(input logic [2:0] f);
        sdac_aux_e a;
        casez (f)
            3'b00?:  a = AUX_NOP;
            3'b01?:  a = AUX_SHDN;
            3'b100:  a = AUX_PIN_LO;
            3'b101:  a = AUX_PIN_HI;
            3'b110:  a = AUX_MODE_ALT;
            default: a = AUX_MODE_STD;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/sdac_sync.sv
// Multi-stage flop synchroniser for a vector of independent single-bit signals.
// Assumes each bit is a level that is stable across several clk periods.
module sdac_sync #(
    parameter int               W       = 3,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First capture stage from the asynchronous pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            // Further resolution stages.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
// Serial receive path: detects serial-clock edges in the system clock
// domain, shifts data while select is low, counts rises modulo the burst
// size and flags a complete word when select rises. Also produces the
// daisy-chain output in either timing mode.
// Assumes synchronised inputs and a serial clock at least 4x slower than clk.
module sdac_shifter #(
    parameter int FRAME_W = 16,
    parameter int SUB_W   = 2,
    parameter int BURST_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n_s,
    input  logic                     sclk_s,
    input  logic                     sdi_s,
    input  logic                     mode_alt,
    output logic [FRAME_W-1:SUB_W]   cmd_bits,
    output logic                     frame_go,
    output logic                     sdo
);
    localparam int CNT_W = (BURST_W > 1) ? $clog2(BURST_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BURST_W - 1);

    logic               sclk_prev_q;
    logic               cs_prev_q;
    logic [FRAME_W-1:0] sr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               any_q;
    logic               go_q;
    logic               half_q;

    logic sclk_rise, sclk_fall, cs_rise, shift_en;

    assign sclk_rise = sclk_s & ~sclk_prev_q;
    assign sclk_fall = ~sclk_s & sclk_prev_q;
    assign cs_rise   = cs_n_s & ~cs_prev_q;
    assign shift_en  = ~cs_n_s & sclk_rise;

    // Edge-detection history for serial clock and select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            cs_prev_q   <= 1'b1;
        end else begin
            sclk_prev_q <= sclk_s;
            cs_prev_q   <= cs_n_s;
        end
    end

    // Shift register: MSB first, one bit per qualified rise.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[FRAME_W-2:0], sdi_s};
    end

    // Rise counter modulo the burst size, cleared while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            cnt_q <= '0;
            any_q <= 1'b0;
        end else if (sclk_rise) begin
            cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
            any_q <= 1'b1;
        end
    end

    // Word-complete strobe on select rise with a whole number of bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= cs_rise & any_q & (cnt_q == '0);
    end

    // Half-period retimed copy of the chain end for the alternate mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                      half_q <= 1'b0;
        else if (~cs_n_s & sclk_fall)    half_q <= sr_q[FRAME_W-1];
    end

    assign cmd_bits = sr_q[FRAME_W-1:SUB_W];
    assign frame_go = go_q;
    assign sdo      = mode_alt ? half_q : sr_q[FRAME_W-1];

    AST_DESELECT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> $stable(sr_q)) else $error("shift while deselected"); // R3
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |=> !go_q) else $error("word strobe longer than one cycle"); // R10
    AST_PARTIAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && cnt_q != '0) |=> !go_q) else $error("partial word accepted"); // R11
    AST_HALF_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(~cs_n_s & sclk_fall) |=> $stable(half_q)) else $error("retimed bit moved off fall"); // R13
endmodule

// File: rtl/sdac_regs.sv
// Command decode and register stages: input stage, output stage, logic
// pin, timing mode and shutdown strobe. Acts only on the one-cycle word
// strobe from the receive path; clear has priority over commands for the pin.
// Assumes cmd_bits is stable while frame_go is high.
module sdac_regs
    import sdac_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CTRL_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_go,
    input  logic [CTRL_W+DATA_W-1:0] cmd_bits,
    input  logic                     clear_in,
    output logic [DATA_W-1:0]        dac_code,
    output logic                     mode_alt,
    output logic                     upo,
    output logic                     shdn_req
);
    localparam int AUX_W = 3;

    logic [DATA_W-1:0] in_q;
    logic [DATA_W-1:0] dac_q;
    logic              upo_q;
    logic              mode_q;
    logic              shdn_q;

    sdac_op_e          op;
    logic [DATA_W-1:0] data;
    sdac_aux_e         aux;
    logic              special;

    assign op      = sdac_op_e'(cmd_bits[CTRL_W+DATA_W-1 -: CTRL_W]);
    assign data    = cmd_bits[DATA_W-1:0];
    assign aux     = decode_aux(data[DATA_W-1 -: AUX_W]);
    assign special = frame_go && (op == OP_SPECIAL);

    // Input stage: written by both load commands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_q <= '0;
        else if (frame_go && (op == OP_LOAD_IN || op == OP_LOAD_ALL))
            in_q <= data;
    end

    // Output stage: written directly or copied from the input stage.
    always_ff @(posedge clk) begin
        if (!rst_n)                             dac_q <= '0;
        else if (frame_go && op == OP_LOAD_ALL) dac_q <= data;
        else if (frame_go && op == OP_TRANSFER) dac_q <= in_q;
    end

    // Logic pin: clear wins, otherwise special words set or clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_in)                  upo_q <= 1'b0;
        else if (special && aux == AUX_PIN_LO)   upo_q <= 1'b0;
        else if (special && aux == AUX_PIN_HI)   upo_q <= 1'b1;
    end

    // Serial-output timing mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                              mode_q <= 1'b0;
        else if (special && aux == AUX_MODE_ALT) mode_q <= 1'b1;
        else if (special && aux == AUX_MODE_STD) mode_q <= 1'b0;
    end

    // Shutdown strobe towards the power controller.
    always_ff @(posedge clk) begin
        if (!rst_n) shdn_q <= 1'b0;
        else        shdn_q <= special && (aux == AUX_SHDN);
    end

    assign dac_code = dac_q;
    assign mode_alt = mode_q;
    assign upo      = upo_q;
    assign shdn_req = shdn_q;

    AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_go |=> $stable(in_q)) else $error("input stage moved without word"); // R4
    AST_LOAD_IN_KEEPS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_go && op == OP_LOAD_IN) |=> $stable(dac_q)) else $error("load-only touched output"); // R4
    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_go |=> $stable(dac_q)) else $error("output stage moved without word"); // R6
    AST_SHDN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_q |=> !shdn_q) else $error("shutdown strobe too wide"); // R7
    AST_CLEAR_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        clear_in |=> !upo_q) else $error("clear did not drop pin"); // R9
    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_go && !clear_in) |=> $stable(upo_q)) else $error("pin moved spontaneously"); // R8
endmodule

// File: rtl/sdac_cmd_front.sv
// Top of the serial DAC command interface: synchronises the three serial
// pins, assembles words and decodes them into the register stages.
// Assumes clear_in is already in the clk domain.
module sdac_cmd_front #(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int BURST_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_in,
    input  logic              sclk_in,
    input  logic              sdi_in,
    input  logic              clear_in,
    output logic [DATA_W-1:0] dac_code,
    output logic              upo,
    output logic              sdo,
    output logic              shdn_req
);
    localparam int CTRL_W  = 2;
    localparam int SUB_W   = 2;
    localparam int FRAME_W = CTRL_W + DATA_W + SUB_W;

    logic [2:0]                 pins_s;
    logic                       frame_go;
    logic                       mode_alt;
    logic [FRAME_W-1:SUB_W]     cmd_bits;

    sdac_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n_in, sclk_in, sdi_in}),
        .q     (pins_s)
    );

    sdac_shifter #(
        .FRAME_W (FRAME_W),
        .SUB_W   (SUB_W),
        .BURST_W (BURST_W)
    ) i_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (pins_s[2]),
        .sclk_s   (pins_s[1]),
        .sdi_s    (pins_s[0]),
        .mode_alt (mode_alt),
        .cmd_bits (cmd_bits),
        .frame_go (frame_go),
        .sdo      (sdo)
    );

    sdac_regs #(
        .DATA_W (DATA_W),
        .CTRL_W (CTRL_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_go (frame_go),
        .cmd_bits (cmd_bits),
        .clear_in (clear_in),
        .dac_code (dac_code),
        .mode_alt (mode_alt),
        .upo      (upo),
        .shdn_req (shdn_req)
    );
endmodule

// File: tb/test_sdac_cmd_front.sv
module test_sdac_cmd_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n_in = 1'b1;
    logic        sclk_in = 1'b0;
    logic        sdi_in = 1'b0;
    logic        clear_in = 1'b0;
    logic [11:0] dac_code;
    logic        upo, sdo, shdn_req;

    always #2 clk = ~clk;

    sdac_cmd_front i_sdac_cmd_front (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sclk_in(sclk_in),
        .sdi_in(sdi_in), .clear_in(clear_in), .dac_code(dac_code),
        .upo(upo), .sdo(sdo), .shdn_req(shdn_req)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // Reference model state
    logic [15:0] m_sr   = '0;
    logic [11:0] m_in   = '0;
    logic [11:0] m_dac  = '0;
    logic        m_upo  = 1'b0;
    logic        m_mode = 1'b0;
    int          shdn_exp  = 0;
    int          shdn_seen = 0;
    int          shdn_wide = 0;
    logic        shdn_prev = 1'b0;

    always @(posedge clk) begin
        if (rst_n && shdn_req) shdn_seen++;
        if (rst_n && shdn_req && shdn_prev) shdn_wide++;
        shdn_prev <= shdn_req;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    function automatic logic [15:0] mk(input logic [1:0] c, input logic [11:0] d,
                                       input logic [1:0] s);
        return {c, d, s};
    endfunction

    // Expected effect of a decoded word on the model.
    task automatic apply(input logic [15:0] w);
        logic [1:0]  c = w[15:14];
        logic [11:0] d = w[13:2];
        case (c)
            2'b00: m_in = d;
            2'b01: begin m_in = d; m_dac = d; end
            2'b10: m_dac = m_in;
            default: begin
                casez (d[11:9])
                    3'b00?: ;
                    3'b01?: shdn_exp++;
                    3'b100: m_upo = 1'b0;
                    3'b101: m_upo = 1'b1;
                    3'b110: m_mode = 1'b1;
                    default: m_mode = 1'b0;
                endcase
            end
        endcase
    endtask

    // One serial period, with sdo checks in both halves.
    task automatic clock_bit(input logic b);
        logic prev;
        string tag;
        sdi_in = b;
        tick(4);
        prev = m_sr[15];
        sclk_in = 1'b1;
        if (!cs_n_in) m_sr = {m_sr[14:0], b};
        tick(6);
        tag = m_mode ? "R13 sdo after rise" : "R12 sdo after rise";
        if (!cs_n_in) chk(tag, 32'(sdo), 32'(m_mode ? prev : m_sr[15]));
        tick(2);
        sclk_in = 1'b0;
        tick(7);
        chk(cs_n_in ? "R3 sdo while deselected" : "R12 R13 sdo after fall",
            32'(sdo), 32'(m_sr[15]));
    endtask

    // Send the low nbits of w, MSB first, with an optional pause before bit gap_at.
    task automatic send(input logic [31:0] w, input int nbits, input int gap_at);
        string tag;
        cs_n_in = 1'b0;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            if (gap_at != 0 && i == gap_at) tick(20);
            clock_bit(w[nbits-1-i]);
        end
        tick(2);
        cs_n_in = 1'b1;
        tick(12);
        if (nbits > 0 && nbits % 8 == 0) apply(m_sr);
        case (m_sr[15:14])
            2'b00: tag = "R4 dac_code";
            2'b01: tag = "R5 dac_code";
            2'b10: tag = "R6 dac_code";
            default: tag = "R7 dac_code";
        endcase
        if (nbits % 8 != 0) tag = "R11 dac_code";
        chk(tag, 32'(dac_code), 32'(m_dac));
        chk((nbits % 8 != 0) ? "R11 upo" : "R8 upo", 32'(upo), 32'(m_upo));
        chk("R7 shdn count", 32'(shdn_seen), 32'(shdn_exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog expired got running expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        tick(10);
        rst_n = 1'b1;
        tick(2);
        chk("R1 dac_code", 32'(dac_code), 0);
        chk("R1 upo", 32'(upo), 0);
        chk("R1 sdo", 32'(sdo), 0);
        chk("R1 shdn_req", 32'(shdn_req), 0);

        send(32'(mk(2'b00, 12'hABC, 2'b00)), 16, 0);   // R4
        send(32'(mk(2'b10, 12'h123, 2'b11)), 16, 0);   // R6
        chk("R6 copy", 32'(dac_code), 32'h00000ABC);
        send(32'(mk(2'b01, 12'h5A5, 2'b11)), 16, 0);   // R5 R2 sub bits ignored
        chk("R2 field position", 32'(dac_code), 32'h000005A5);
        send(32'(mk(2'b00, 12'h0F0, 2'b00)), 16, 0);   // R4
        chk("R4 dac held", 32'(dac_code), 32'h000005A5);
        send(32'(mk(2'b10, 12'hFFF, 2'b00)), 16, 0);   // R6
        chk("R6 copy", 32'(dac_code), 32'h000000F0);

        send(32'(mk(2'b11, 12'hA00, 2'b00)), 16, 0);   // R8 high
        chk("R8 pin high", 32'(upo), 1);
        send(32'(mk(2'b11, 12'h0FF, 2'b00)), 16, 0);   // R7 nop
        send(32'(mk(2'b11, 12'h400, 2'b00)), 16, 0);   // R7 shutdown
        chk("R7 pin kept", 32'(upo), 1);
        chk("R7 dac kept", 32'(dac_code), 32'h000000F0);

        clear_in = 1'b1;                                // R9
        tick(1);
        clear_in = 1'b0;
        tick(1);
        m_upo = 1'b0;
        chk("R9 clear", 32'(upo), 0);

        send(32'(mk(2'b01, 12'h3C3, 2'b00)), 16, 8);   // R10 two bursts
        chk("R10 split word", 32'(dac_code), 32'h000003C3);
        send(32'h00000777, 12, 0);                      // R11 discard
        chk("R11 discarded", 32'(dac_code), 32'h000003C3);
        send(32'h0000005A, 8, 0);                       // R10 8-bit burst
        send({8'h00, 8'h5E, mk(2'b01, 12'h9D1, 2'b01)}, 24, 0); // R10 chained
        chk("R10 last 16 bits", 32'(dac_code), 32'h000009D1);

        for (int i = 0; i < 10; i++) clock_bit(1'($urandom));   // R3
        chk("R3 dac unchanged", 32'(dac_code), 32'h000009D1);
        send(32'(mk(2'b01, 12'h246, 2'b00)), 16, 0);
        chk("R3 next word clean", 32'(dac_code), 32'h00000246);

        send(32'(mk(2'b11, 12'hC00, 2'b00)), 16, 0);   // R13 alternate
        send(32'(mk(2'b01, 12'h8E1, 2'b10)), 16, 0);
        send(32'(mk(2'b00, 12'h111, 2'b00)), 16, 5);
        send(32'(mk(2'b11, 12'hE00, 2'b00)), 16, 0);   // R13 back to standard
        send(32'(mk(2'b10, 12'h000, 2'b00)), 16, 0);

        for (int n = 0; n < 70; n++) begin
            int nb;
            int pick = int'($urandom_range(0, 9));
            logic [31:0] w = $urandom;
            nb = (pick < 6) ? 16 : (pick == 6) ? 8 : (pick == 7) ? 24 : (pick == 8) ? 12 : 5;
            if (nb == 16) w[15:0] = mk(2'($urandom), 12'($urandom), 2'($urandom));
            send(w, nb, (pick == 0) ? 8 : 0);
        end

        chk("R7 pulse width", 32'(shdn_wide), 0);
        finish_run();
    end
endmodule